// File: doc/BRIEF.md
# Up-Counting Timer with Update-Event Control

This block is an up-counting timer. A prescaler divides the timer clock by a programmable ratio. Each prescaler tick advances a 16-bit counter. When the counter reaches the active reload value, it wraps to zero. The prescale ratio and the reload limit each have two copies: a value that software writes, and an active shadow copy. The shadow copies take the written values only on an update event.

An update event comes from a counter overflow or from a software event strobe. Two control bits decide whether an event happens at all and which sources may raise the sticky interrupt flag. The block also has these features:
- a one-shot mode, which stops the counter by itself;
- a choice between a buffered and an immediate reload limit;
- a sampling-clock enable output, divided by 1, 2 or 4, for later input filters;
- an option to show the interrupt flag in the top bit of the counter read value.

Software reaches the block through a single-cycle register port. Writes take effect at the clock edge where the write strobe is high. Reads are combinational.

Top module: `upd_timer`

## Requirements
- R1: The counter and prescaler advance only while the run bit (control bit 0) is 1. With run at 0 the counter holds its value.
- R2: While the update-off bit (control bit 1) is 1, no update event happens. Overflow and the event strobe neither set the flag nor load the active prescale or reload copy.
- R3: Writing 1 to bit 0 of the event register (address 3) clears the counter and prescaler at that edge, whatever the update-off bit holds.
- R4: With update-off at 0, an overflow or an event strobe is an update event. On that event the active prescale and reload copies load the written values.
- R5: With the overflow-only bit (control bit 2) at 1, only an overflow sets the flag. With that bit at 0, the event strobe sets the flag as well.
- R6: With the one-shot bit (control bit 3) at 1, an update event clears the run bit. This hardware clear wins over a software write in the same cycle.
- R7: With the reload-buffer bit (control bit 4) at 0, a written reload limit is in use at once. With that bit at 1, the limit in use changes only on an update event.
- R8: The sampling enable samp_en_o is high every cycle for divider code 0 or 3 (control bits 6:5). It is high every second cycle for code 1 and every fourth cycle for code 2.
- R9: With the mirror bit (control bit 7) at 1, bit 31 of the counter read value (address 4) is the flag. Otherwise bit 31 reads 0.
- R10: The flag (status register, address 2, bit 0) is sticky. Writing 0 to it clears it, and writing 1 has no effect. irq_o is the flag ANDed with bit 0 of the interrupt-enable register (address 1).
- R11: The prescaler divides by the active prescale value plus 1. A tick with the counter equal to the active reload limit is an overflow, and the counter returns to 0. A write to address 4 loads the counter.
- R12: After reset, all control bits, the flag, the counter and the prescaler read 0. The reload limit (address 6) reads 0x0000FFFF, and the prescale value (address 5) reads 0.
- R13: The write-side prescale and reload values read back at addresses 5 and 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Timer clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i |
| irq_o | output | 1 | Update interrupt request |
| samp_en_o | output | 1 | Divided sampling-clock enable |

## Verification
A register write changes state at the rising edge where its strobe is high. The bench drives each write at a falling edge and reads back at the next falling edge, so exactly one edge lies between them. With a prescale value of 0 the counter steps on the first edge after enabling. The overflow, and with it the flag, lands on the edge where the counter equals the reload limit. With a prescale value of N, every step takes N+1 edges. Each check waits a counted number of falling edges from a known write, so the expected count, flag and run bit are fixed numbers. The sampling enable is checked by counting pulses over eight cycles, which does not depend on its phase.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned DATA_W = 32;

  localparam logic [2:0] A_CTRL  = 3'd0;
  localparam logic [2:0] A_IEN   = 3'd1;
  localparam logic [2:0] A_STAT  = 3'd2;
  localparam logic [2:0] A_EVGEN = 3'd3;
  localparam logic [2:0] A_COUNT = 3'd4;
  localparam logic [2:0] A_PRESC = 3'd5;
  localparam logic [2:0] A_RELD  = 3'd6;

  typedef struct packed {
    logic       flag_mirror;
    logic [1:0] samp_div;
    logic       reload_buf;
    logic       one_shot;
    logic       ovf_only;
    logic       upd_off;
    logic       run;
  } ctrl_t;
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [2:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              run_clr_i,
  input  logic              flag_set_i,
  output ctrl_t             ctrl_o,
  output logic              irq_en_o,
  output logic              flag_o,
  output logic [CNT_W-1:0]  psc_pre_o,
  output logic [CNT_W-1:0]  arr_pre_o,
  output logic              ug_o,
  output logic              cnt_wr_o
);
  localparam int unsigned PAD_W = DATA_W - CNT_W - 1;

  ctrl_t            ctrl_q;
  logic             ien_q, flag_q;
  logic [CNT_W-1:0] psc_q, arr_q;

  logic wr_ctrl, wr_ien, wr_stat, wr_psc, wr_arr;
  assign wr_ctrl  = wr_en_i && (addr_i == A_CTRL);
  assign wr_ien   = wr_en_i && (addr_i == A_IEN);
  assign wr_stat  = wr_en_i && (addr_i == A_STAT);
  assign wr_psc   = wr_en_i && (addr_i == A_PRESC);
  assign wr_arr   = wr_en_i && (addr_i == A_RELD);
  assign ug_o     = wr_en_i && (addr_i == A_EVGEN) && wdata_i[0];
  assign cnt_wr_o = wr_en_i && (addr_i == A_COUNT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      ien_q  <= 1'b0;
      flag_q <= 1'b0;
      psc_q  <= '0;
      arr_q  <= '1;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_t'(wdata_i[7:0]);
      if (run_clr_i) ctrl_q.run <= 1'b0;   // hw stop wins
      if (wr_ien) ien_q <= wdata_i[0];
      if (flag_set_i) flag_q <= 1'b1;
      else if (wr_stat && !wdata_i[0]) flag_q <= 1'b0;
      if (wr_psc) psc_q <= wdata_i[CNT_W-1:0];
      if (wr_arr) arr_q <= wdata_i[CNT_W-1:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_CTRL:  rdata_o = {{(DATA_W-8){1'b0}}, ctrl_q};
      A_IEN:   rdata_o = {{(DATA_W-1){1'b0}}, ien_q};
      A_STAT:  rdata_o = {{(DATA_W-1){1'b0}}, flag_q};
      A_COUNT: rdata_o = {ctrl_q.flag_mirror & flag_q, {PAD_W{1'b0}}, cnt_i};
      A_PRESC: rdata_o = {{(DATA_W-CNT_W){1'b0}}, psc_q};
      A_RELD:  rdata_o = {{(DATA_W-CNT_W){1'b0}}, arr_q};
      default: rdata_o = '0;
    endcase
  end

  assign ctrl_o    = ctrl_q;
  assign irq_en_o  = ien_q;
  assign flag_o    = flag_q;
  assign psc_pre_o = psc_q;
  assign arr_pre_o = arr_q;
endmodule

// File: rtl/tmr_core.sv
module tmr_core #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             upd_off_i,
  input  logic             ovf_only_i,
  input  logic             one_shot_i,
  input  logic             reload_buf_i,
  input  logic [CNT_W-1:0] psc_pre_i,
  input  logic [CNT_W-1:0] arr_pre_i,
  input  logic             ug_i,
  input  logic             cnt_wr_i,
  input  logic [CNT_W-1:0] cnt_wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] psc_act_o,
  output logic             ovf_o,
  output logic             uev_o,
  output logic             flag_set_o,
  output logic             run_clr_o
);
  logic [CNT_W-1:0] psc_cnt_q, psc_act_q, arr_sh_q, cnt_q, arr_eff;
  logic             tick;

  assign arr_eff    = reload_buf_i ? arr_sh_q : arr_pre_i;
  assign tick       = run_i && (psc_cnt_q == psc_act_q);
  assign ovf_o      = tick && (cnt_q == arr_eff);
  assign uev_o      = !upd_off_i && (ovf_o || ug_i);
  assign flag_set_o = !upd_off_i && (ovf_o || (ug_i && !ovf_only_i));
  assign run_clr_o  = one_shot_i && uev_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      psc_cnt_q <= '0;
      cnt_q     <= '0;
    end else begin
      if (ug_i)       psc_cnt_q <= '0;
      else if (tick)  psc_cnt_q <= '0;
      else if (run_i) psc_cnt_q <= psc_cnt_q + 1'b1;

      if (ug_i)          cnt_q <= '0;
      else if (cnt_wr_i) cnt_q <= cnt_wdata_i;
      else if (tick)     cnt_q <= ovf_o ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      psc_act_q <= '0;
      arr_sh_q  <= '1;
    end else if (uev_o) begin
      psc_act_q <= psc_pre_i;
      arr_sh_q  <= arr_pre_i;
    end
  end

  assign cnt_o     = cnt_q;
  assign psc_act_o = psc_act_q;
endmodule

// File: rtl/tmr_samp_div.sv
module tmr_samp_div #(
  parameter int unsigned CODE_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] code_i,
  output logic              en_o
);
  localparam int unsigned DIV_W = 2;

  logic [DIV_W-1:0] div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) div_q <= '0;
    else         div_q <= div_q + 1'b1;
  end

  always_comb begin
    unique case (code_i)
      2'd1:    en_o = div_q[0];
      2'd2:    en_o = &div_q;
      default: en_o = 1'b1;  // 0 and reserved 3
    endcase
  end
endmodule

// File: rtl/upd_timer.sv
module upd_timer
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [2:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o,
  output logic              samp_en_o
);
  ctrl_t            ctrl;
  logic             irq_en, flag, ug, cnt_wr, ovf, uev, flag_set, run_clr;
  logic [CNT_W-1:0] psc_pre, arr_pre, cnt_val, psc_act;

  tmr_regs #(.CNT_W(CNT_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i, .rdata_o,
    .cnt_i(cnt_val), .run_clr_i(run_clr), .flag_set_i(flag_set),
    .ctrl_o(ctrl), .irq_en_o(irq_en), .flag_o(flag),
    .psc_pre_o(psc_pre), .arr_pre_o(arr_pre), .ug_o(ug), .cnt_wr_o(cnt_wr)
  );

  tmr_core #(.CNT_W(CNT_W)) u_core (
    .clk_i, .rst_ni,
    .run_i(ctrl.run), .upd_off_i(ctrl.upd_off), .ovf_only_i(ctrl.ovf_only),
    .one_shot_i(ctrl.one_shot), .reload_buf_i(ctrl.reload_buf),
    .psc_pre_i(psc_pre), .arr_pre_i(arr_pre), .ug_i(ug), .cnt_wr_i(cnt_wr),
    .cnt_wdata_i(wdata_i[CNT_W-1:0]),
    .cnt_o(cnt_val), .psc_act_o(psc_act), .ovf_o(ovf), .uev_o(uev),
    .flag_set_o(flag_set), .run_clr_o(run_clr)
  );

  tmr_samp_div #(.CODE_W(2)) u_samp (
    .clk_i, .rst_ni, .code_i(ctrl.samp_div), .en_o(samp_en_o)
  );

  assign irq_o = flag & irq_en;
endmodule

// File: rtl/upd_timer_chk.sv
module upd_timer_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             run_i,
  input logic             upd_off_i,
  input logic             ovf_only_i,
  input logic             one_shot_i,
  input logic             ug_i,
  input logic             cnt_wr_i,
  input logic             ovf_i,
  input logic             uev_i,
  input logic             flag_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic [CNT_W-1:0] psc_act_i,
  input logic [1:0]       samp_div_i,
  input logic             samp_en_i,
  input logic             irq_i
);
  p_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !ug_i && !cnt_wr_i) |=> $stable(cnt_i));

  p_shadow_keep_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_off_i |=> $stable(psc_act_i));

  p_ug_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ug_i |=> (cnt_i == '0));

  p_ovf_src_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_only_i && !ovf_i && !flag_i) |=> !flag_i);

  p_one_shot_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (one_shot_i && uev_i) |=> !run_i);

  p_full_rate_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (samp_div_i == 2'd0) |-> samp_en_i);

  p_no_irq_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flag_i |-> !irq_i);

  p_wrap_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_i && !cnt_wr_i) |=> (cnt_i == '0));
endmodule

bind upd_timer upd_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .run_i(ctrl.run), .upd_off_i(ctrl.upd_off),
  .ovf_only_i(ctrl.ovf_only), .one_shot_i(ctrl.one_shot), .ug_i(ug),
  .cnt_wr_i(cnt_wr), .ovf_i(ovf), .uev_i(uev), .flag_i(flag), .cnt_i(cnt_val),
  .psc_act_i(psc_act), .samp_div_i(ctrl.samp_div), .samp_en_i(samp_en_o),
  .irq_i(irq_o)
);

// File: tb/sim_upd_timer.sv
module sim_upd_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, samp_en;
  int          n_chk = 0, n_bad = 0;
  logic        done = 1'b0;

  localparam logic [2:0] CTRL = 0, IEN = 1, STAT = 2, EVG = 3, CNT = 4, PSC = 5, RLD = 6;

  upd_timer u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .samp_en_o(samp_en)
  );

  always #10 clk = ~clk;

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  // called at a falling edge; returns at the falling edge after the write edge
  task automatic wr(logic [2:0] a, logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd_chk(string tag, logic [2:0] a, logic [31:0] exp);
    addr = a;
    #1;
    chk(tag, rdata, exp);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    step(2);
    rst_n = 1'b1;
    step(1);
  endtask

  task automatic t_reset();
    do_reset();
    rd_chk("R12 ctrl", CTRL, 0);
    rd_chk("R12 count", CNT, 0);
    rd_chk("R12 presc", PSC, 0);
    rd_chk("R12 reload", RLD, 32'h0000_ffff);
    rd_chk("R12 flag", STAT, 0);
    chk("R12 irq", {31'b0, irq}, 0);
  endtask

  task automatic t_overflow();
    do_reset();
    wr(RLD, 3);                        // R7 immediate limit
    wr(CTRL, 1);
    step(3);
    rd_chk("R11 count before wrap", CNT, 3);
    rd_chk("R11 flag before wrap", STAT, 0);
    step(1);
    rd_chk("R11 R7 wrap", CNT, 0);
    rd_chk("R4 overflow flag", STAT, 1);
    wr(CTRL, 0);
    chk("R10 irq masked", {31'b0, irq}, 0);
    wr(IEN, 1);
    chk("R10 irq enabled", {31'b0, irq}, 1);
    wr(STAT, 1);
    rd_chk("R10 write1 no effect", STAT, 1);
    wr(STAT, 0);
    rd_chk("R10 clear", STAT, 0);
    chk("R10 irq after clear", {31'b0, irq}, 0);
    rd_chk("R13 reload readback", RLD, 3);
  endtask

  task automatic t_hold();
    do_reset();
    wr(RLD, 100);
    wr(CTRL, 1);
    step(5);
    rd_chk("R1 running", CNT, 5);
    wr(CTRL, 0);
    step(5);
    rd_chk("R1 held", CNT, 6);
  endtask

  task automatic t_upd_off();
    do_reset();
    wr(CTRL, 2);
    wr(PSC, 5);
    rd_chk("R13 presc readback", PSC, 5);
    wr(CNT, 7);
    rd_chk("R11 count write", CNT, 7);
    wr(EVG, 1);
    rd_chk("R3 reinit while off", CNT, 0);
    rd_chk("R2 no flag on strobe", STAT, 0);
    wr(RLD, 2);
    wr(CTRL, 3);
    step(4);
    rd_chk("R2 prescale not loaded", CNT, 1);
    rd_chk("R2 no flag on overflow", STAT, 0);
  endtask

  task automatic t_strobe_load();
    do_reset();
    wr(PSC, 1);
    wr(EVG, 1);
    rd_chk("R4 strobe sets flag", STAT, 1);
    wr(STAT, 0);
    wr(CTRL, 1);
    step(4);
    rd_chk("R4 R11 divide by two", CNT, 2);
    step(1);
    rd_chk("R11 between ticks", CNT, 2);
  endtask

  task automatic t_src();
    do_reset();
    wr(CTRL, 4);
    wr(EVG, 1);
    rd_chk("R5 strobe ignored", STAT, 0);
    wr(RLD, 1);
    wr(CTRL, 5);
    step(2);
    rd_chk("R5 overflow sets", STAT, 1);
    rd_chk("R5 wrapped", CNT, 0);
  endtask

  task automatic t_one_shot();
    do_reset();
    wr(RLD, 2);
    wr(CTRL, 9);
    step(5);
    rd_chk("R6 stopped count", CNT, 0);
    rd_chk("R6 run cleared", CTRL, 8);
    rd_chk("R6 flag", STAT, 1);
  endtask

  task automatic t_buffered();
    do_reset();
    wr(CTRL, 16);
    wr(RLD, 3);
    wr(CTRL, 17);
    step(6);
    rd_chk("R7 old limit kept", CNT, 6);
    rd_chk("R7 no overflow", STAT, 0);
    wr(EVG, 1);
    rd_chk("R7 strobe clears", CNT, 0);
    wr(STAT, 0);
    step(3);
    rd_chk("R7 new limit wrap", CNT, 0);
    rd_chk("R7 new limit flag", STAT, 1);
  endtask

  task automatic t_samp();
    do_reset();
    for (int code = 0; code < 4; code++) begin
      int ones = 0;
      int exp;
      wr(CTRL, 32'(code) << 5);
      for (int i = 0; i < 8; i++) begin
        #1;
        ones += int'(samp_en);
        step(1);
      end
      exp = (code == 1) ? 4 : (code == 2) ? 2 : 8;
      chk($sformatf("R8 pulses code %0d", code), 32'(ones), 32'(exp));
    end
  endtask

  task automatic t_mirror();
    do_reset();
    wr(EVG, 1);
    rd_chk("R9 mirror off", CNT, 0);
    wr(CTRL, 128);
    rd_chk("R9 mirror on", CNT, 32'h8000_0000);
    wr(STAT, 0);
    rd_chk("R9 mirror cleared flag", CNT, 0);
  endtask

  initial begin
    step(1);
    t_reset();
    t_overflow();
    t_hold();
    t_upd_off();
    t_strobe_load();
    t_src();
    t_one_shot();
    t_buffered();
    t_samp();
    t_mirror();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule